// File: doc/BRIEF.md
# Sigma-Delta Converter Operating-Mode Sequencer

This block is the digital control sequencer for a sigma-delta converter. A register interface gives it a 3-bit operating mode, a 3-bit channel select and a 3-bit gain code. It also receives a tick once per output-data period, together with the filter's result word, which is valid on that tick. From these inputs the sequencer decides when a result is latched into the data register. It drives an active-low ready flag, holds the modulator and filter in reset or in power-down, and writes calibration coefficients into per-channel offset and full-scale registers.

Every accepted write to the mode, the configuration (channel and gain) or the IO register restarts the current operation. The first result then takes two data periods. In continuous operation each later period produces one result. In single-shot operation one result is produced, the converter powers down, and the flag stays low until the result is read. A calibration runs for two or four periods, stores the tick's result as the channel's coefficient, and then drops to idle on its own. An internal full-scale calibration at the highest gain is refused.

The gain code gives the gain as two raised to the code: code 0 is gain 1 and code 7 is gain 128. The mode codes are 000 continuous, 001 single, 010 idle, 011 power-down, 100 internal zero-scale calibration, 101 internal full-scale calibration, 110 system offset calibration and 111 system full-scale calibration. The states are ST_SETTLE (continuous, waiting for the first result), ST_STREAM (continuous, one result per tick), ST_SINGLE (single-shot conversion), ST_HOLD (single-shot result held, powered down), ST_CAL (calibrating), ST_IDLE and ST_OFF. The transitions are:
- ST_SETTLE goes to ST_STREAM on the second tick.
- ST_STREAM loops to itself on every tick.
- ST_SINGLE goes to ST_HOLD on the second tick.
- ST_CAL goes to ST_IDLE on its last tick.
- Any accepted write moves the machine to the entry state of the effective mode: 000 to ST_SETTLE, 001 to ST_SINGLE, 010 to ST_IDLE, 011 to ST_OFF, 1xx to ST_CAL.

Top module: `adc_mode_seq`

## Requirements
- R1: After reset the mode is 000 and the sequencer is in ST_SETTLE with no ticks counted. rdy_n is 1, mod_rst and pwr_dn are 0 and cal_err is 0. Every offset coefficient is 0 and every full-scale coefficient equals PRESET_G1 (default 24'h800000).
- R2: In continuous mode (000), the first result is latched on the second tick after reset or after any accepted write. That tick's conv_result appears on data_out with rdy_n low in the following cycle. After that, every tick latches a new result.
- R3: An accepted mode write, any configuration write and any IO write each set rdy_n to 1 in the next cycle and restart the period count. A tick in the same cycle as such a write is not counted.
- R4: A data_rd pulse sets rdy_n to 1 until the next latch. When a latch and a read fall in the same cycle, the latch wins and rdy_n goes low.
- R5: In single mode (001), pwr_dn is 0 until the second tick. That tick's result is then latched, rdy_n goes low, and pwr_dn and mod_rst become 1. Later ticks leave data_out and rdy_n unchanged until a read or a new write. A new write in mode 001 starts another conversion with pwr_dn 0.
- R6: In idle mode (010), mod_rst is 1 and pwr_dn is 0. In power-down mode (011), both are 1. In both modes, ticks change neither data_out nor rdy_n.
- R7: Modes 100, 110 and 111 calibrate for 2 ticks. Mode 101 calibrates for 2 ticks at gain code 0 and for 4 ticks at gain codes 1 to 6. rdy_n is 1 during a calibration. On the last tick rdy_n goes low and the mode becomes 010.
- R8: A calibration in mode 100 or 110 writes the last tick's conv_result into the offset coefficient of the selected channel. A calibration in mode 101 or 111 writes it into that channel's full-scale coefficient. No other channel and no other coefficient changes.
- R9: A mode write of 101 while the effective gain code is 7 is rejected. The mode is kept, no restart occurs and cal_err becomes 1. A configuration write that sets gain code 7 while the mode is 101 forces the mode to 010 and sets cal_err. The next accepted mode write clears cal_err.
- R10: A configuration write with gain code 0 loads PRESET_G1 into the full-scale coefficient of the written channel. Gain code 7 loads PRESET_G128 (default 24'h7FF000). All other codes leave that coefficient unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_in | input | 3 | Mode code to write |
| cfg_we | input | 1 | Configuration register write strobe |
| chan_in | input | CHAN_W | Channel select to write |
| gain_in | input | GAIN_W | Gain code to write |
| io_we | input | 1 | IO register write strobe (restart only) |
| conv_tick | input | 1 | One pulse per output-data period |
| conv_result | input | DATA_W | Filter result, valid with conv_tick |
| data_rd | input | 1 | Data register read strobe |
| coef_chan | input | CHAN_W | Channel whose coefficients are shown |
| rdy_n | output | 1 | Ready flag, active low |
| data_out | output | DATA_W | Data register |
| mode_out | output | 3 | Current mode code |
| cal_err | output | 1 | Sticky rejected-calibration flag |
| mod_rst | output | 1 | Modulator and filter held in reset |
| pwr_dn | output | 1 | Converter circuitry powered down |
| off_coef | output | DATA_W | Offset coefficient of coef_chan |
| fs_coef | output | DATA_W | Full-scale coefficient of coef_chan |

## Verification
Writes, reads and coefficient loads show their effect one cycle after the strobe. Latches and calibration completions show theirs one cycle after the counted tick: the 2nd tick after a write, or the 4th for a long calibration. Each task drives its stimulus for exactly one cycle starting at a falling edge, and checks at the next falling edge. As a result, every comparison falls in the first cycle the result is due. Holding and ignoring behaviour is checked after further ticks, in the same way.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        MODE_CONT        = 3'b000,
        MODE_SINGLE      = 3'b001,
        MODE_IDLE        = 3'b010,
        MODE_OFF         = 3'b011,
        MODE_CAL_ZERO    = 3'b100,
        MODE_CAL_FS_INT  = 3'b101,
        MODE_CAL_SYS_OFF = 3'b110,
        MODE_CAL_SYS_FS  = 3'b111
    } mode_t;

    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_STREAM,
        ST_SINGLE,
        ST_HOLD,
        ST_CAL,
        ST_IDLE,
        ST_OFF
    } seq_state_t;

    // State entered when an operation (re)starts in the given mode.
    function automatic seq_state_t entry_state(input mode_t m);
        seq_state_t s;
        unique case (m)
            MODE_CONT:   s = ST_SETTLE;
            MODE_SINGLE: s = ST_SINGLE;
            MODE_IDLE:   s = ST_IDLE;
            MODE_OFF:    s = ST_OFF;
            default:     s = ST_CAL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int DATA_W        = 24,
    parameter int FIRST_PERIODS = 2,
    parameter int CAL_SHORT     = 2,
    parameter int CAL_LONG      = 4,
    localparam int MAX_PERIODS  = (CAL_LONG > FIRST_PERIODS) ? CAL_LONG : FIRST_PERIODS,
    localparam int CNT_W        = $clog2(MAX_PERIODS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  mode_t             entry_mode,
    input  logic              long_cal,
    input  logic              tick,
    input  logic [DATA_W-1:0] result,
    input  logic              data_rd,
    output logic              rdy_n,
    output logic [DATA_W-1:0] data_q,
    output logic              cal_done,
    output logic              mod_rst,
    output logic              pwr_dn
);

    localparam logic [CNT_W-1:0] FIRST_LAST = CNT_W'(FIRST_PERIODS - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(CAL_SHORT - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(CAL_LONG - 1);

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0]  cal_last_q, cal_last_d;
    logic              rdy_n_q, rdy_n_d;
    logic              latch;
    logic              done;

    // Next-state logic: restart has priority, then the counted tick.
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        cal_last_d = cal_last_q;
        latch      = 1'b0;
        done       = 1'b0;
        if (restart) begin
            state_d    = entry_state(entry_mode);
            cnt_d      = '0;
            cal_last_d = long_cal ? LONG_LAST : SHORT_LAST;
        end else if (tick) begin
            unique case (state_q)
                ST_SETTLE: begin
                    if (cnt_q == FIRST_LAST) begin
                        latch   = 1'b1;
                        state_d = ST_STREAM;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_STREAM: latch = 1'b1;
                ST_SINGLE: begin
                    if (cnt_q == FIRST_LAST) begin
                        latch   = 1'b1;
                        state_d = ST_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_CAL: begin
                    if (cnt_q == cal_last_q) begin
                        done    = 1'b1;
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_HOLD, ST_IDLE, ST_OFF: ;
            endcase
        end

        if (restart)            rdy_n_d = 1'b1;
        else if (latch || done) rdy_n_d = 1'b0;
        else if (data_rd)       rdy_n_d = 1'b1;
        else                    rdy_n_d = rdy_n_q;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_SETTLE;
            cnt_q      <= '0;
            cal_last_q <= SHORT_LAST;
            rdy_n_q    <= 1'b1;
            data_q     <= '0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            cal_last_q <= cal_last_d;
            rdy_n_q    <= rdy_n_d;
            if (latch) data_q <= result;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        mod_rst = 1'b0;
        pwr_dn  = 1'b0;
        unique case (state_q)
            ST_IDLE: mod_rst = 1'b1;
            ST_OFF, ST_HOLD: begin
                mod_rst = 1'b1;
                pwr_dn  = 1'b1;
            end
            ST_SETTLE, ST_STREAM, ST_SINGLE, ST_CAL: ;
        endcase
    end

    assign rdy_n    = rdy_n_q;
    assign cal_done = done;

endmodule

// File: rtl/adc_seq_coef_bank.sv
module adc_seq_coef_bank #(
    parameter int          CHAN_W   = 3,
    parameter int          DATA_W   = 24,
    parameter logic [DATA_W-1:0] RESET_FS = '0,
    localparam int         NCH      = 1 << CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              off_we,
    input  logic              fs_we,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CHAN_W-1:0] rd_chan,
    output logic [DATA_W-1:0] off_rd,
    output logic [DATA_W-1:0] fs_rd
);

    logic [DATA_W-1:0] off_q [NCH];
    logic [DATA_W-1:0] fs_q  [NCH];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_q[ch] <= '0;
                fs_q[ch]  <= RESET_FS;
            end else if (wr_chan == CHAN_W'(ch)) begin
                if (off_we) off_q[ch] <= wr_data;
                if (fs_we)  fs_q[ch]  <= wr_data;
            end
        end
    end

    assign off_rd = off_q[rd_chan];
    assign fs_rd  = fs_q[rd_chan];

endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
    import adc_seq_pkg::*;
#(
    parameter int                DATA_W        = 24,
    parameter int                CHAN_W        = 3,
    parameter int                GAIN_W        = 3,
    parameter int                FIRST_PERIODS = 2,
    parameter int                CAL_SHORT     = 2,
    parameter int                CAL_LONG      = 4,
    parameter logic [DATA_W-1:0] PRESET_G1     = 24'h800000,
    parameter logic [DATA_W-1:0] PRESET_G128   = 24'h7FF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [2:0]        mode_in,
    input  logic              cfg_we,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic [GAIN_W-1:0] gain_in,
    input  logic              io_we,
    input  logic              conv_tick,
    input  logic [DATA_W-1:0] conv_result,
    input  logic              data_rd,
    input  logic [CHAN_W-1:0] coef_chan,
    output logic              rdy_n,
    output logic [DATA_W-1:0] data_out,
    output logic [2:0]        mode_out,
    output logic              cal_err,
    output logic              mod_rst,
    output logic              pwr_dn,
    output logic [DATA_W-1:0] off_coef,
    output logic [DATA_W-1:0] fs_coef
);

    localparam logic [GAIN_W-1:0] GAIN_UNITY = '0;
    localparam logic [GAIN_W-1:0] GAIN_TOP   = '1;

    mode_t             mode_q, mode_cand, mode_eff;
    logic [CHAN_W-1:0] chan_q;
    logic [GAIN_W-1:0] gain_q, gain_eff;
    logic              err_q;
    logic              mode_req_bad, cfg_bad, restart, long_cal, cal_done;
    logic              preset_we, off_we, fs_we;
    logic [DATA_W-1:0] coef_wdata;
    logic [CHAN_W-1:0] coef_wchan;

    // Write decode: effective gain, rejection of the forbidden calibration.
    always_comb begin
        gain_eff     = cfg_we ? gain_in : gain_q;
        mode_req_bad = mode_we && (mode_t'(mode_in) == MODE_CAL_FS_INT) && (gain_eff == GAIN_TOP);
        mode_cand    = (mode_we && !mode_req_bad) ? mode_t'(mode_in) : mode_q;
        cfg_bad      = cfg_we && (mode_cand == MODE_CAL_FS_INT) && (gain_eff == GAIN_TOP);
        mode_eff     = cfg_bad ? MODE_IDLE : mode_cand;
        restart      = (mode_we && !mode_req_bad) || cfg_we || io_we;
        long_cal     = (mode_eff == MODE_CAL_FS_INT) && (gain_eff != GAIN_UNITY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_CONT;
            chan_q <= '0;
            gain_q <= GAIN_UNITY;
            err_q  <= 1'b0;
        end else begin
            if (restart)       mode_q <= mode_eff;
            else if (cal_done) mode_q <= MODE_IDLE;
            if (cfg_we) begin
                chan_q <= chan_in;
                gain_q <= gain_in;
            end
            if (mode_req_bad || cfg_bad) err_q <= 1'b1;
            else if (mode_we)            err_q <= 1'b0;
        end
    end

    adc_seq_fsm #(
        .DATA_W        (DATA_W),
        .FIRST_PERIODS (FIRST_PERIODS),
        .CAL_SHORT     (CAL_SHORT),
        .CAL_LONG      (CAL_LONG)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .entry_mode (mode_eff),
        .long_cal   (long_cal),
        .tick       (conv_tick),
        .result     (conv_result),
        .data_rd    (data_rd),
        .rdy_n      (rdy_n),
        .data_q     (data_out),
        .cal_done   (cal_done),
        .mod_rst    (mod_rst),
        .pwr_dn     (pwr_dn)
    );

    // Coefficient writes: calibration result or gain preset (never both,
    // since a configuration write restarts the sequencer).
    always_comb begin
        preset_we  = cfg_we && ((gain_in == GAIN_UNITY) || (gain_in == GAIN_TOP));
        off_we     = cal_done && !mode_q[0];
        fs_we      = (cal_done && mode_q[0]) || preset_we;
        coef_wchan = preset_we ? chan_in : chan_q;
        if (preset_we) coef_wdata = (gain_in == GAIN_TOP) ? PRESET_G128 : PRESET_G1;
        else           coef_wdata = conv_result;
    end

    adc_seq_coef_bank #(
        .CHAN_W   (CHAN_W),
        .DATA_W   (DATA_W),
        .RESET_FS (PRESET_G1)
    ) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .off_we  (off_we),
        .fs_we   (fs_we),
        .wr_chan (coef_wchan),
        .wr_data (coef_wdata),
        .rd_chan (coef_chan),
        .off_rd  (off_coef),
        .fs_rd   (fs_coef)
    );

    assign mode_out = mode_q;
    assign cal_err  = err_q;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              cal_done,
    input logic [GAIN_W-1:0] gain_q,
    input logic              rdy_n,
    input logic              conv_tick,
    input logic [DATA_W-1:0] conv_result,
    input logic [DATA_W-1:0] data_out,
    input logic [2:0]        mode_out,
    input logic              mod_rst,
    input logic              pwr_dn
);

    assert_restart_raises_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> rdy_n);

    assert_ready_fall_has_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rdy_n) && mode_out != 3'b010) |-> ($past(conv_tick) && data_out == $past(conv_result)));

    assert_idle_gating_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out == 3'b010) |-> (mod_rst && !pwr_dn));

    assert_powered_down_holds_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn && !restart) |=> $stable(data_out));

    assert_cal_end_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> (mode_out == 3'b010 && !rdy_n));

    assert_no_fs_cal_at_top_gain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_out == 3'b101 && gain_q == '1));

endmodule

bind adc_mode_seq adc_seq_checker #(
    .DATA_W (DATA_W),
    .GAIN_W (GAIN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .cal_done    (cal_done),
    .gain_q      (gain_q),
    .rdy_n       (rdy_n),
    .conv_tick   (conv_tick),
    .conv_result (conv_result),
    .data_out    (data_out),
    .mode_out    (mode_out),
    .mod_rst     (mod_rst),
    .pwr_dn      (pwr_dn)
);

// File: tb/adc_mode_seq_tb.sv
module adc_mode_seq_tb;

    localparam logic [23:0] P_G1   = 24'h800000;
    localparam logic [23:0] P_G128 = 24'h7FF000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [2:0]  mode_in = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  chan_in = '0;
    logic [2:0]  gain_in = '0;
    logic        io_we = 1'b0;
    logic        conv_tick = 1'b0;
    logic [23:0] conv_result = '0;
    logic        data_rd = 1'b0;
    logic [2:0]  coef_chan = '0;
    logic        rdy_n;
    logic [23:0] data_out;
    logic [2:0]  mode_out;
    logic        cal_err, mod_rst, pwr_dn;
    logic [23:0] off_coef, fs_coef;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_mode_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
        .cfg_we(cfg_we), .chan_in(chan_in), .gain_in(gain_in), .io_we(io_we),
        .conv_tick(conv_tick), .conv_result(conv_result), .data_rd(data_rd),
        .coef_chan(coef_chan), .rdy_n(rdy_n), .data_out(data_out),
        .mode_out(mode_out), .cal_err(cal_err), .mod_rst(mod_rst),
        .pwr_dn(pwr_dn), .off_coef(off_coef), .fs_coef(fs_coef)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // All stimulus tasks start and end at a falling edge.
    task automatic tick(input logic [23:0] v);
        conv_tick = 1'b1; conv_result = v;
        @(negedge clk);
        conv_tick = 1'b0;
    endtask

    task automatic wr_mode(input logic [2:0] m);
        mode_we = 1'b1; mode_in = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic wr_cfg(input logic [2:0] ch, input logic [2:0] g);
        cfg_we = 1'b1; chan_in = ch; gain_in = g;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic coef(input string req, input logic [2:0] ch,
                        input logic [23:0] exp_off, input logic [23:0] exp_fs);
        coef_chan = ch;
        #1;
        chk({req, " offset"}, 32'(off_coef), 32'(exp_off));
        chk({req, " fullscale"}, 32'(fs_coef), 32'(exp_fs));
    endtask

    task automatic t_reset();
        chk("R1 rdy_n", 32'(rdy_n), 1);
        chk("R1 mode", 32'(mode_out), 0);
        chk("R1 mod_rst", 32'(mod_rst), 0);
        chk("R1 pwr_dn", 32'(pwr_dn), 0);
        chk("R1 cal_err", 32'(cal_err), 0);
        coef("R1", 3'd3, 24'h0, P_G1);
    endtask

    task automatic t_continuous();
        tick(24'h0000A1);
        chk("R2 first tick no result", 32'(rdy_n), 1);
        tick(24'h0000B2);
        chk("R2 second tick rdy", 32'(rdy_n), 0);
        chk("R2 second tick data", 32'(data_out), 32'h0000B2);
        tick(24'h0000C3);
        chk("R2 every tick data", 32'(data_out), 32'h0000C3);
        rd();
        chk("R4 read raises rdy", 32'(rdy_n), 1);
        data_rd = 1'b1;
        tick(24'h0000D4);
        data_rd = 1'b0;
        chk("R4 latch beats read", 32'(rdy_n), 0);
        chk("R4 latch data", 32'(data_out), 32'h0000D4);
    endtask

    task automatic t_restart();
        io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
        chk("R3 io write raises rdy", 32'(rdy_n), 1);
        io_we = 1'b1;
        tick(24'h0000E5);
        io_we = 1'b0;
        tick(24'h0000F6);
        chk("R3 tick with write not counted", 32'(rdy_n), 1);
        tick(24'h000107);
        chk("R3 restart latency rdy", 32'(rdy_n), 0);
        chk("R3 restart latency data", 32'(data_out), 32'h000107);
    endtask

    task automatic t_single();
        wr_mode(3'b001);
        chk("R5 start rdy", 32'(rdy_n), 1);
        chk("R5 powered during conversion", 32'(pwr_dn), 0);
        tick(24'h000111);
        chk("R5 first tick", 32'(rdy_n), 1);
        tick(24'h000222);
        chk("R5 result rdy", 32'(rdy_n), 0);
        chk("R5 result data", 32'(data_out), 32'h000222);
        chk("R5 power-down after", 32'(pwr_dn), 1);
        chk("R5 reset after", 32'(mod_rst), 1);
        tick(24'h000333);
        chk("R5 hold data", 32'(data_out), 32'h000222);
        chk("R5 hold rdy", 32'(rdy_n), 0);
        rd();
        chk("R5 read rdy", 32'(rdy_n), 1);
        chk("R5 read keeps data", 32'(data_out), 32'h000222);
        wr_mode(3'b001);
        chk("R5 another conversion powers up", 32'(pwr_dn), 0);
    endtask

    task automatic t_idle_off();
        wr_mode(3'b010);
        chk("R6 idle mod_rst", 32'(mod_rst), 1);
        chk("R6 idle pwr_dn", 32'(pwr_dn), 0);
        tick(24'h000444);
        tick(24'h000555);
        chk("R6 idle ignores ticks rdy", 32'(rdy_n), 1);
        chk("R6 idle ignores ticks data", 32'(data_out), 32'h000222);
        wr_mode(3'b011);
        chk("R6 off pwr_dn", 32'(pwr_dn), 1);
        chk("R6 off mod_rst", 32'(mod_rst), 1);
        tick(24'h000666);
        tick(24'h000777);
        chk("R6 off ignores ticks rdy", 32'(rdy_n), 1);
        chk("R6 off ignores ticks data", 32'(data_out), 32'h000222);
    endtask

    task automatic t_cal_zero();
        wr_cfg(3'd2, 3'd1);
        wr_mode(3'b100);
        tick(24'h010101);
        chk("R7 zero cal busy rdy", 32'(rdy_n), 1);
        chk("R7 zero cal busy mode", 32'(mode_out), 4);
        tick(24'h0A0A0A);
        chk("R7 zero cal done rdy", 32'(rdy_n), 0);
        chk("R7 zero cal to idle", 32'(mode_out), 2);
        coef("R8 zero cal ch2", 3'd2, 24'h0A0A0A, P_G1);
        coef("R8 zero cal ch1 untouched", 3'd1, 24'h0, P_G1);
    endtask

    task automatic t_cal_fs_long();
        wr_cfg(3'd5, 3'd3);
        wr_mode(3'b101);
        for (int i = 0; i < 3; i++) tick(24'h020000 + 24'(i));
        chk("R7 long fs cal busy rdy", 32'(rdy_n), 1);
        chk("R7 long fs cal busy mode", 32'(mode_out), 5);
        tick(24'h0B0B0B);
        chk("R7 long fs cal done rdy", 32'(rdy_n), 0);
        chk("R7 long fs cal to idle", 32'(mode_out), 2);
        coef("R8 fs cal ch5", 3'd5, 24'h0, 24'h0B0B0B);
    endtask

    task automatic t_cal_fs_short();
        wr_cfg(3'd4, 3'd0);
        coef("R10 gain1 preset", 3'd4, 24'h0, P_G1);
        wr_mode(3'b101);
        tick(24'h030303);
        tick(24'h0C0C0C);
        chk("R7 unity fs cal 2 ticks", 32'(rdy_n), 0);
        chk("R7 unity fs cal to idle", 32'(mode_out), 2);
        coef("R8 unity fs cal ch4", 3'd4, 24'h0, 24'h0C0C0C);
    endtask

    task automatic t_cal_system();
        wr_cfg(3'd6, 3'd2);
        wr_mode(3'b110);
        tick(24'h040404);
        tick(24'h0D0D0D);
        chk("R7 sys offset cal 2 ticks", 32'(rdy_n), 0);
        coef("R8 sys offset ch6", 3'd6, 24'h0D0D0D, P_G1);
        wr_cfg(3'd7, 3'd2);
        wr_mode(3'b111);
        tick(24'h050505);
        tick(24'h0E0E0E);
        chk("R7 sys fs cal 2 ticks", 32'(rdy_n), 0);
        chk("R7 sys fs to idle", 32'(mode_out), 2);
        coef("R8 sys fs ch7", 3'd7, 24'h0, 24'h0E0E0E);
    endtask

    task automatic t_reject();
        wr_cfg(3'd1, 3'd7);
        coef("R10 gain128 preset", 3'd1, 24'h0, P_G128);
        wr_mode(3'b101);
        chk("R9 rejected mode kept", 32'(mode_out), 2);
        chk("R9 rejected sets err", 32'(cal_err), 1);
        wr_mode(3'b010);
        chk("R9 next write clears err", 32'(cal_err), 0);
        wr_cfg(3'd1, 3'd5);
        coef("R10 other code keeps", 3'd1, 24'h0, P_G128);
        wr_mode(3'b101);
        chk("R9 accepted fs cal", 32'(mode_out), 5);
        wr_cfg(3'd1, 3'd7);
        chk("R9 cfg abort to idle", 32'(mode_out), 2);
        chk("R9 cfg abort err", 32'(cal_err), 1);
        tick(24'h060606);
        tick(24'h070707);
        chk("R9 aborted cal no result", 32'(rdy_n), 1);
        coef("R9 aborted cal no write", 3'd1, 24'h0, P_G128);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_continuous();
        t_restart();
        t_single();
        t_idle_off();
        t_cal_zero();
        t_cal_fs_long();
        t_cal_fs_short();
        t_cal_system();
        t_reject();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule